// File: doc/BRIEF.md
# DVMA Page Translation Engine

The engine turns device virtual address requests into physical segments. A device hands over one request at a time: a start address, a byte count and a direction. The engine cuts the request at every 4 KB page boundary. For each page it reads one 32-bit entry from a single-level page table in memory and checks that entry. It then emits one physical segment per page, with a 36-bit physical address, a length and a direction. Whatever moves the data consumes these segments.

The table origin is a configuration word shifted left by four. Only the part of the virtual address that lies inside a top-of-space window selects the entry. The window size is programmable from 16 MB up to 2 GB. An entry that is not valid stops the request, and so does a write to a page that is not writeable. When a request stops this way, the engine loads a fault status word and the page-aligned faulting address, and raises an interrupt. The interrupt stays high until it is acknowledged. Segments issued before the fault stand. The remaining bytes are dropped.

Top module: `dvma_xlate`

## Requirements
- R1: After reset, req_ready is 1; seg_valid, mem_req_valid, done and irq are 0; flt_status is 0x00800000; flt_addr is 0.
- R2: A request is cut into segments. Each segment ends at the next 4 KB boundary or at the end of the request, whichever comes first, and the segments come out in ascending address order.
- R3: The entry for a page is read from (cfg_base << 4) + 4 * ((vaddr & (2^(24+cfg_win_sel) - 1)) >> 12). The read data is a big-endian word, with bits [31:24] holding the lowest-addressed byte.
- R4: seg_paddr = {entry[31:8], vaddr[11:0]}, and seg_write equals the request direction. seg_attr = {entry[7], entry[0]} is passed through unchecked.
- R5: An entry with bit 1 clear produces no segment for its page and ends the request with done_err = 1.
- R6: A write request to a page whose entry has bit 2 clear faults like R5. A read of such a page translates normally.
- R7: On a fault, flt_status becomes 0xC0820000, or 0xC0860000 when the request was a read. flt_addr becomes the page-aligned virtual address of the failing page, and irq goes to 1.
- R8: Segments issued before a fault are kept and no further segment follows. Every request ends with a single-cycle done pulse, and done_err is valid alongside it.
- R9: A request with length 0 finishes with done and done_err = 0. It issues no table read and no segment.
- R10: irq stays 1 until irq_ack is asserted, including across later successful requests. irq_ack clears irq and leaves flt_status and flt_addr unchanged.
- R11: req_ready is 0 from acceptance until the done cycle. seg and memory request outputs hold steady while they are stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | VA_W | Table origin, shifted left by 4 |
| cfg_win_sel | input | WSEL_W | Window size code, giving a window of 2^(24+code) bytes |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted |
| req_addr | input | VA_W | Start virtual address |
| req_len | input | LEN_W | Byte count |
| req_write | input | 1 | 1 = write, 0 = read |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Table read accepted |
| mem_req_addr | output | PA_W | Table entry address |
| mem_rsp_valid | input | 1 | Table data returned |
| mem_rsp_data | input | 32 | Entry word, big-endian |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment taken |
| seg_paddr | output | PA_W | Segment physical address |
| seg_len | output | LEN_W | Segment byte count |
| seg_write | output | 1 | Segment direction |
| seg_attr | output | 2 | {cacheable, write-as-zeros}, passed through from the entry |
| done | output | 1 | Request finished (one cycle) |
| done_err | output | 1 | Request ended with a fault |
| irq_ack | input | 1 | Clears irq |
| irq | output | 1 | Fault interrupt |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | VA_W | Page-aligned faulting address |

## Verification
The bench builds the engine with its default parameters: 32-bit virtual addresses, 36-bit physical addresses, a 16-bit length, 4 KB pages and a 16 MB smallest window. The 16-bit length allows requests of several pages, so a request can start and end in the middle of a page. Window codes 0, 1 and 7 show that the index drops the address bits above the window. The table model returns entries whose frame number encodes the entry index. A wrong table address therefore shows up as a wrong physical address.

// File: rtl/dvma_pkg.sv
package dvma_pkg;

  localparam int PTE_W = 32;

  // entry flag bit positions (decoded by the check stage)
  localparam int PTE_VALID_BIT = 1;
  localparam int PTE_WRITE_BIT = 2;
  localparam int PTE_CACHE_BIT = 7;
  localparam int PTE_WAZ_BIT   = 0;

  // fault status word components
  localparam logic [31:0] FST_ERR   = 32'h8000_0000;
  localparam logic [31:0] FST_LATE  = 32'h4000_0000;
  localparam logic [31:0] FST_RESV  = 32'h0080_0000;
  localparam logic [31:0] FST_RD    = 32'h0004_0000;
  localparam logic [31:0] FST_AVAL  = 32'h0002_0000;
  localparam logic [31:0] FST_FAULT = FST_ERR | FST_LATE | FST_RESV | FST_AVAL;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_FETCH,
    XS_WAIT,
    XS_SEG,
    XS_DONE
  } xl_state_e;

endpackage

// File: rtl/dvma_chunk.sv
module dvma_chunk #(
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [PAGE_SHIFT-1:0] off_i,
  input  logic [LEN_W-1:0]      remain_i,
  output logic [LEN_W-1:0]      chunk_o,
  output logic                  last_o
);
  localparam logic [LEN_W-1:0] PAGE_BYTES = LEN_W'(1) << PAGE_SHIFT;

  logic [LEN_W-1:0] left;

  assign left    = PAGE_BYTES - LEN_W'(off_i);
  assign last_o  = (remain_i <= left);
  assign chunk_o = last_o ? remain_i : left;
endmodule

// File: rtl/dvma_pte_index.sv
module dvma_pte_index #(
  parameter int VA_W          = 32,
  parameter int PA_W          = 36,
  parameter int PAGE_SHIFT    = 12,
  parameter int WIN_MIN_SHIFT = 24,
  parameter int WSEL_W        = 3
) (
  input  logic [VA_W-1:0]   base_i,
  input  logic [WSEL_W-1:0] win_sel_i,
  input  logic [VA_W-1:0]   va_i,
  output logic [PA_W-1:0]   entry_addr_o
);
  localparam int SH_W = $clog2(VA_W) + 2;

  logic [SH_W-1:0] win_sh;
  logic [VA_W-1:0] win_mask;
  logic [VA_W-1:0] win_off;

  assign win_sh   = SH_W'(WIN_MIN_SHIFT) + SH_W'(win_sel_i);
  assign win_mask = ~({VA_W{1'b1}} << win_sh);
  assign win_off  = va_i & win_mask;
  assign entry_addr_o = (PA_W'(base_i) << 4) + (PA_W'(win_off >> PAGE_SHIFT) << 2);
endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check
  import dvma_pkg::*;
#(
  parameter int PPN_W = 24
) (
  input  logic [PTE_W-1:0] entry_i,
  input  logic             is_write_i,
  output logic             fault_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic [1:0]       attr_o
);
  logic [PTE_W-PPN_W-5:0] unused_bits;

  assign fault_o = !entry_i[PTE_VALID_BIT] || (is_write_i && !entry_i[PTE_WRITE_BIT]);
  assign ppn_o   = entry_i[PTE_W-1 -: PPN_W];
  assign attr_o  = {entry_i[PTE_CACHE_BIT], entry_i[PTE_WAZ_BIT]};
  assign unused_bits = entry_i[PTE_W-PPN_W-2:3];
endmodule

// File: rtl/dvma_fault_regs.sv
module dvma_fault_regs
  import dvma_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_i,
  input  logic            set_read_i,
  input  logic [VA_W-1:0] set_va_i,
  input  logic            ack_i,
  output logic [31:0]     status_o,
  output logic [VA_W-1:0] addr_o,
  output logic            irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= FST_RESV;
      addr_o   <= '0;
      irq_o    <= 1'b0;
    end else if (set_i) begin
      status_o <= FST_FAULT | (set_read_i ? FST_RD : 32'h0);
      addr_o   <= set_va_i;
      irq_o    <= 1'b1;
    end else if (ack_i) begin
      irq_o    <= 1'b0;
    end
  end

  a_r7_fault_load: assert property (@(posedge clk) disable iff (rst)
    set_i |=> irq_o && status_o[31] && status_o[17] && (addr_o == $past(set_va_i)));

  a_r10_irq_hold: assert property (@(posedge clk) disable iff (rst)
    irq_o && !ack_i |=> irq_o);

  a_r10_ack_keeps_status: assert property (@(posedge clk) disable iff (rst)
    ack_i && !set_i |=> !irq_o && $stable(status_o) && $stable(addr_o));
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
#(
  parameter int VA_W          = 32,
  parameter int PA_W          = 36,
  parameter int LEN_W         = 16,
  parameter int PAGE_SHIFT    = 12,
  parameter int WIN_MIN_SHIFT = 24,
  parameter int WSEL_W        = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VA_W-1:0]   cfg_base,
  input  logic [WSEL_W-1:0] cfg_win_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [PA_W-1:0]   seg_paddr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_write,
  output logic [1:0]        seg_attr,
  output logic              done,
  output logic              done_err,
  input  logic              irq_ack,
  output logic              irq,
  output logic [31:0]       flt_status,
  output logic [VA_W-1:0]   flt_addr
);
  localparam int PPN_W = PA_W - PAGE_SHIFT;
  localparam logic [LEN_W:0] PAGE_BYTES = (LEN_W+1)'(1) << PAGE_SHIFT;

  xl_state_e        st;
  logic [VA_W-1:0]  cur_va;
  logic [LEN_W-1:0] remain;
  logic             wr_q;
  logic             err_q;
  logic [PA_W-1:0]  mem_addr_q;
  logic [PA_W-1:0]  seg_pa_q;
  logic [LEN_W-1:0] seg_len_q;
  logic [1:0]       seg_attr_q;

  logic [LEN_W-1:0] chunk;
  logic             last;
  logic [VA_W-1:0]  va_next;
  logic [VA_W-1:0]  idx_va;
  logic [PA_W-1:0]  ent_addr;
  logic             pte_fault;
  logic [PPN_W-1:0] ppn;
  logic [1:0]       attr;
  logic             flt_set;
  logic [VA_W-1:0]  page_va;

  assign va_next = cur_va + VA_W'(chunk);
  assign idx_va  = (st == XS_IDLE) ? req_addr : va_next;
  assign page_va = {cur_va[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign flt_set = (st == XS_WAIT) && mem_rsp_valid && pte_fault;

  dvma_chunk #(.LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_chunk (
    .off_i    (cur_va[PAGE_SHIFT-1:0]),
    .remain_i (remain),
    .chunk_o  (chunk),
    .last_o   (last)
  );

  dvma_pte_index #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT),
    .WIN_MIN_SHIFT(WIN_MIN_SHIFT), .WSEL_W(WSEL_W)
  ) u_index (
    .base_i       (cfg_base),
    .win_sel_i    (cfg_win_sel),
    .va_i         (idx_va),
    .entry_addr_o (ent_addr)
  );

  dvma_pte_check #(.PPN_W(PPN_W)) u_check (
    .entry_i    (mem_rsp_data),
    .is_write_i (wr_q),
    .fault_o    (pte_fault),
    .ppn_o      (ppn),
    .attr_o     (attr)
  );

  dvma_fault_regs #(.VA_W(VA_W)) u_fault (
    .clk        (clk),
    .rst        (rst),
    .set_i      (flt_set),
    .set_read_i (!wr_q),
    .set_va_i   (page_va),
    .ack_i      (irq_ack),
    .status_o   (flt_status),
    .addr_o     (flt_addr),
    .irq_o      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= XS_IDLE;
      cur_va     <= '0;
      remain     <= '0;
      wr_q       <= 1'b0;
      err_q      <= 1'b0;
      mem_addr_q <= '0;
      seg_pa_q   <= '0;
      seg_len_q  <= '0;
      seg_attr_q <= '0;
    end else begin
      case (st)
        XS_IDLE: if (req_valid) begin
          cur_va     <= req_addr;
          remain     <= req_len;
          wr_q       <= req_write;
          err_q      <= 1'b0;
          mem_addr_q <= ent_addr;
          st         <= (req_len == '0) ? XS_DONE : XS_FETCH;
        end
        XS_FETCH: if (mem_req_ready) st <= XS_WAIT;
        XS_WAIT: if (mem_rsp_valid) begin
          if (pte_fault) begin
            err_q <= 1'b1;
            st    <= XS_DONE;
          end else begin
            seg_pa_q   <= {ppn, cur_va[PAGE_SHIFT-1:0]};
            seg_len_q  <= chunk;
            seg_attr_q <= attr;
            st         <= XS_SEG;
          end
        end
        XS_SEG: if (seg_ready) begin
          cur_va     <= va_next;
          remain     <= remain - chunk;
          mem_addr_q <= ent_addr;
          st         <= last ? XS_DONE : XS_FETCH;
        end
        default: st <= XS_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == XS_IDLE);
  assign mem_req_valid = (st == XS_FETCH);
  assign mem_req_addr  = mem_addr_q;
  assign seg_valid     = (st == XS_SEG);
  assign seg_paddr     = seg_pa_q;
  assign seg_len       = seg_len_q;
  assign seg_write     = wr_q;
  assign seg_attr      = seg_attr_q;
  assign done          = (st == XS_DONE);
  assign done_err      = err_q;

  a_r11_busy: assert property (@(posedge clk) disable iff (rst)
    (seg_valid || mem_req_valid || done) |-> !req_ready);

  a_r2_in_page: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> (seg_len != '0) &&
      ((LEN_W+1)'(seg_paddr[PAGE_SHIFT-1:0]) + (LEN_W+1)'(seg_len) <= PAGE_BYTES));

  a_r11_seg_hold: assert property (@(posedge clk) disable iff (rst)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_paddr) && $stable(seg_len));

  a_r3_mem_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_no_seg_after_fault: assert property (@(posedge clk) disable iff (rst)
    flt_set |=> done && !seg_valid);
endmodule

// File: tb/dvma_xlate_bench.sv
module dvma_xlate_bench;
  localparam int VA_W = 32, PA_W = 36, LEN_W = 16;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic        wr;
    logic [2:0]  sel;
    logic [19:0] bad;
    logic [19:0] ro;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    {32'hFF00_0100, 16'h0100, 1'b0, 3'd0, 20'hFFFFF, 20'hFFFFF}, // single page read
    {32'hFF00_0F00, 16'h0300, 1'b1, 3'd0, 20'hFFFFF, 20'hFFFFF}, // crosses one boundary
    {32'hFF80_2000, 16'h3000, 1'b0, 3'd1, 20'hFFFFF, 20'hFFFFF}, // three whole pages, 32MB window
    {32'h8000_5800, 16'h2000, 1'b1, 3'd7, 20'hFFFFF, 20'hFFFFF}, // 2GB window, partial ends
    {32'hFF01_0000, 16'h2800, 1'b0, 3'd0, 20'h00011, 20'hFFFFF}, // invalid 2nd page
    {32'hFF02_0800, 16'h1000, 1'b1, 3'd0, 20'hFFFFF, 20'h00020}, // write to read-only
    {32'hFF02_0800, 16'h1000, 1'b0, 3'd0, 20'hFFFFF, 20'h00020}, // read of read-only
    {32'hFF03_0000, 16'h0000, 1'b0, 3'd0, 20'hFFFFF, 20'hFFFFF}  // zero length
  };

  localparam logic [31:0] BASE = 32'h0012_3400;
  localparam logic [35:0] ORG  = 36'(BASE) << 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] cfg_win_sel = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [VA_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic seg_ready = 1'b0, irq_ack = 1'b0;
  logic req_ready, mem_req_valid, seg_valid, seg_write, done, done_err, irq;
  logic [PA_W-1:0] mem_req_addr, seg_paddr;
  logic [LEN_W-1:0] seg_len;
  logic [1:0] seg_attr;
  logic [31:0] flt_status;
  logic [VA_W-1:0] flt_addr;

  int n_chk = 0, n_fail = 0;
  logic [19:0] cur_bad = 20'hFFFFF, cur_ro = 20'hFFFFF;

  always #5 clk = ~clk;

  dvma_xlate u_dvma_xlate (
    .clk(clk), .rst(rst), .cfg_base(BASE), .cfg_win_sel(cfg_win_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_paddr(seg_paddr),
    .seg_len(seg_len), .seg_write(seg_write), .seg_attr(seg_attr),
    .done(done), .done_err(done_err), .irq_ack(irq_ack), .irq(irq),
    .flt_status(flt_status), .flt_addr(flt_addr)
  );

  function automatic logic [31:0] pte_of(input logic [19:0] idx);
    logic [31:0] e;
    e = {4'h9, idx, 8'h81};
    if (idx != cur_bad) e[1] = 1'b1;
    if (idx != cur_ro)  e[2] = 1'b1;
    return e;
  endfunction

  task automatic chk(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // table memory model: ready stalls every third cycle, data one cycle after acceptance
  initial begin
    logic pend;
    logic [35:0] paddr;
    int cyc;
    pend = 1'b0; paddr = '0; cyc = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        logic [35:0] off;
        off = paddr - ORG;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = (off[1:0] == 2'b00 && off[35:22] == '0) ? pte_of(off[21:2]) : 32'h0;
        pend = 1'b0;
      end
      cyc++;
      mem_req_ready = (cyc % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1'b1;
        paddr = mem_req_addr;
      end
    end
  end

  task automatic run_vec(input vec_t v, input int vn);
    logic [35:0] e_pa [32];
    logic [15:0] e_len [32];
    int ne, got, ready_pat;
    logic e_err, fin;
    logic [31:0] e_fa, e_st, a, pte;
    int rem, ch;
    logic [31:0] mask;
    cur_bad = v.bad; cur_ro = v.ro;
    ne = 0; e_err = 1'b0; e_fa = '0; e_st = '0;
    mask = (v.sel == 3'd7) ? 32'h7FFF_FFFF : ((32'h1 << (24 + v.sel)) - 1);
    a = v.addr; rem = int'(v.len);
    while (rem > 0) begin
      ch = 4096 - int'(a[11:0]);
      if (rem < ch) ch = rem;
      pte = pte_of(20'((a & mask) >> 12));
      if (!pte[1] || (v.wr && !pte[2])) begin
        e_err = 1'b1;
        e_fa  = {a[31:12], 12'h000};
        e_st  = v.wr ? 32'hC082_0000 : 32'hC086_0000;
        break;
      end
      e_pa[ne] = {pte[31:8], a[11:0]};
      e_len[ne] = 16'(ch);
      ne++;
      a = a + 32'(ch);
      rem = rem - ch;
    end

    @(negedge clk);
    chk("R11 idle before request", req_ready == 1'b1, 64'(req_ready), 64'd1);
    cfg_win_sel = v.sel; req_addr = v.addr; req_len = v.len; req_write = v.wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 busy after accept", req_ready == 1'b0 || (v.len == 0), 64'(req_ready), 64'd0);
    got = 0; fin = 1'b0; ready_pat = vn;
    for (int c = 0; c < 4000 && !fin; c++) begin
      if (c > 0) @(negedge clk);
      seg_ready = (ready_pat % 4) != 1;
      ready_pat++;
      if (seg_valid && seg_ready) begin
        if (got < ne) begin
          chk("R2 R3 R4 segment", seg_paddr == e_pa[got] && seg_len == e_len[got]
              && seg_write == v.wr && seg_attr == 2'b11,
              {11'(seg_attr), seg_write, seg_len, seg_paddr}, {11'd3, v.wr, e_len[got], e_pa[got]});
        end else begin
          chk("R8 no extra segment", 1'b0, 64'(seg_paddr), 64'd0);
        end
        got++;
      end
      if (done) begin
        fin = 1'b1;
        chk("R8 R9 segment count", got == ne, 64'(got), 64'(ne));
        chk("R5 R6 R8 done_err", done_err == e_err, 64'(done_err), 64'(e_err));
        if (e_err) begin
          chk("R7 fault status", flt_status == e_st, 64'(flt_status), 64'(e_st));
          chk("R7 fault address", flt_addr == e_fa, 64'(flt_addr), 64'(e_fa));
          chk("R7 irq raised", irq == 1'b1, 64'(irq), 64'd1);
        end
      end
    end
    chk("R8 request finished", fin == 1'b1, 64'(fin), 64'd1);
    @(negedge clk);
    chk("R8 done single cycle", done == 1'b0, 64'(done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] st_keep;
    logic [31:0] fa_keep;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", req_ready == 1'b1, 64'(req_ready), 64'd1);
    chk("R1 outputs idle", !seg_valid && !mem_req_valid && !done && !irq,
        {seg_valid, mem_req_valid, done, irq}, 64'd0);
    chk("R1 status", flt_status == 32'h0080_0000, 64'(flt_status), 64'h0080_0000);
    chk("R1 fault address", flt_addr == '0, 64'(flt_addr), 64'd0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], i);
      if (i == 4 || i == 6)
        chk("R10 irq held", irq == 1'b1, 64'(irq), 64'd1);
    end

    // R10 acknowledge clears irq, keeps the fault record
    st_keep = flt_status; fa_keep = flt_addr;
    chk("R10 record kept over later requests", st_keep == 32'hC082_0000 && fa_keep == 32'hFF02_0000,
        {st_keep, fa_keep}, {32'hC082_0000, 32'hFF02_0000});
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R10 irq cleared", irq == 1'b0, 64'(irq), 64'd0);
    chk("R10 status unchanged", flt_status == st_keep && flt_addr == fa_keep,
        {flt_status, flt_addr}, {st_keep, fa_keep});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule